// File: doc/BRIEF.md
# Multi-Source Chip Reset Controller

This block gathers every reset origin of a chip into one protected hard-reset net and three command-driven reset domains. The hard reset is active low. It is the AND of four active-low terms:

- a pair of reset pads;
- a power-up reset;
- an inverted three-cell radiation vote;
- a trigger-pattern run detector.

The pads, the power-up input and the radiation vote assert the net at once, without a clock. Their release passes through a two-flop synchroniser. A second pad pair can invert the whole hard-reset net through an XOR mask, for test and recovery.

Three command strobes from an external decoder set up the domain resets:

- A system command resets the general logic domain only.
- A soft command resets the register domain and also the logic domain.
- A PLL command produces a long, counted high-active pulse.

A hard reset drives both the logic and the register domains low. It also returns the PLL stretcher to idle.

Two small state machines carry the sequencing:

- **Trigger detector**, states `TR_RUN` and `TR_FIRE`.
  - `TR_RUN` counts matching command slots.
  - `TR_RUN -> TR_FIRE` happens on the run's last match.
  - `TR_FIRE -> TR_RUN` is unconditional after one cycle.
- **PLL stretcher**, states `PL_IDLE` and `PL_HOLD`.
  - `PL_IDLE -> PL_HOLD` happens on a request.
  - `PL_HOLD -> PL_HOLD` reloads the count on a request or counts down.
  - `PL_HOLD -> PL_IDLE` happens when the count is zero and there is no request.

Top module: `chip_reset_hub`

## Requirements
- R1: If either reset pad (`pad_rst_a_n`, `pad_rst_b_n`) is low, `hard_rst_n` goes low with no clock edge needed, while both mask pads are high.
- R2: A low `por_n` asserts `hard_rst_n` at once. After all asynchronous sources release, `hard_rst_n` rises at the second rising clock edge.
- R3: The radiation vote asserts `hard_rst_n` only when all three bits of `rad_hit` are 1. With two of three bits high, it has no effect.
- R4: `TRIG_RUN` consecutive slots with `slot_valid=1` and `slot_match=1` drive `hard_rst_n` low. This lasts exactly one cycle, starting after the edge that samples the last match. A slot with `slot_valid=0` neither counts nor clears. A valid slot with `slot_match=0` clears the run.
- R5: The mask term is 1 when either mask pad (`xor_pad_a_n`, `xor_pad_b_n`) is low. `hard_rst_n` equals the combined hard reset XOR this term, so with a pad low an idle chip sees `hard_rst_n=0` and a reset chip sees 1.
- R6: A `cmd_sys` pulse sampled at an edge drives `logic_rst_n` low for one cycle after that edge. `reg_rst_n` and `pll_rst` are unchanged.
- R7: A `cmd_soft` pulse drives both `logic_rst_n` and `reg_rst_n` low for one cycle after the sampling edge. `pll_rst` is unchanged.
- R8: A `cmd_pll` pulse raises `pll_rst` for exactly `PLL_CYCLES` cycles after the sampling edge. `logic_rst_n` and `reg_rst_n` are unchanged.
- R9: A `cmd_pll` that arrives while `pll_rst` is high restarts the count. `pll_rst` then stays high for `PLL_CYCLES` cycles after that later request.
- R10: While `hard_rst_n` is low, `logic_rst_n` and `reg_rst_n` are low and `pll_rst` is 0, taking effect at once. The domain outputs rise at the first edge after `hard_rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pad_rst_a_n | input | 1 | Reset pad A, active low |
| pad_rst_b_n | input | 1 | Reset pad B, active low |
| por_n | input | 1 | Power-up reset, active low |
| rad_hit | input | 3 | Radiation cell flags, active high |
| slot_valid | input | 1 | A command slot is present this cycle |
| slot_match | input | 1 | The present slot carries the trigger pattern |
| xor_pad_a_n | input | 1 | Mask pad A, active low |
| xor_pad_b_n | input | 1 | Mask pad B, active low |
| cmd_sys | input | 1 | Decoded system-reset strobe |
| cmd_soft | input | 1 | Decoded soft-reset strobe |
| cmd_pll | input | 1 | Decoded PLL-reset strobe |
| hard_rst_n | output | 1 | Masked hard reset, active low |
| logic_rst_n | output | 1 | Logic-domain reset, active low |
| reg_rst_n | output | 1 | Register-domain reset, active low |
| pll_rst | output | 1 | Stretched PLL reset, active high |

## Verification
The bench builds the block with `TRIG_RUN=5` and `PLL_CYCLES=9` instead of 32 and 160. This puts the run detector's last-match firing and its clear-on-mismatch path within a handful of slots, and lets every cycle of a whole PLL pulse be checked one by one. It also lets a restarted PLL pulse be counted from the second request to its end. The synchroniser depth stays at two, so the release timing of the hard reset and the domains is checked exactly as it is built.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic {
        TR_RUN  = 1'b0,
        TR_FIRE = 1'b1
    } trig_state_t;

    typedef enum logic {
        PL_IDLE = 1'b0,
        PL_HOLD = 1'b1
    } pll_state_t;

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_n,
    output logic sync_n
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge async_n) begin
                if (!async_n) chain_q <= '0;
                else          chain_q <= 1'b1;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge async_n) begin
                if (!async_n) chain_q <= '0;
                else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rstc_trig_run.sv
module rstc_trig_run
    import rstc_pkg::*;
#(
    parameter int RUN_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_valid,
    input  logic slot_match,
    output logic fire_n
);

    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    trig_state_t    state_q, state_nx;
    logic [CW-1:0]  cnt_q, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TR_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            TR_RUN: begin
                if (slot_valid) begin
                    if (!slot_match) begin
                        cnt_nx = '0;
                    end else if (cnt_q == LAST) begin
                        cnt_nx   = '0;
                        state_nx = TR_FIRE;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            TR_FIRE: begin
                cnt_nx   = '0;
                state_nx = TR_RUN;
            end
            default: begin
                cnt_nx   = '0;
                state_nx = TR_RUN;
            end
        endcase
    end

    always_comb begin
        fire_n = (state_q != TR_FIRE);
    end

    // R4: a firing cycle follows a sampled matching slot
    a_r4_fire_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fire_n) |-> $past(slot_valid && slot_match));

    // R4: the generated reset lasts one cycle only
    a_r4_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_n |=> fire_n);

    // R4: the run counter never passes the run length
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/rstc_pll_stretch.sv
module rstc_pll_stretch
    import rstc_pkg::*;
#(
    parameter int CYCLES = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pulse
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

    pll_state_t    state_q, state_nx;
    logic [CW-1:0] cnt_q, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            PL_IDLE: begin
                if (req) begin
                    state_nx = PL_HOLD;
                    cnt_nx   = RELOAD;
                end
            end
            PL_HOLD: begin
                if (req) begin
                    cnt_nx = RELOAD;
                end else if (cnt_q == '0) begin
                    state_nx = PL_IDLE;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            default: begin
                state_nx = PL_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        pulse = (state_q == PL_HOLD);
    end

    // R8: a request always leaves the pulse high next cycle
    a_r8_req_starts: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pulse);

    // R9: a request reloads the full count
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (cnt_q == RELOAD));

    // R8: the pulse ends only after the count has run out
    a_r8_ends_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> $past(cnt_q == '0));

endmodule

// File: rtl/chip_reset_hub.sv
module chip_reset_hub #(
    parameter int TRIG_RUN    = 32,
    parameter int PLL_CYCLES  = 160,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       pad_rst_a_n,
    input  logic       pad_rst_b_n,
    input  logic       por_n,
    input  logic [2:0] rad_hit,
    input  logic       slot_valid,
    input  logic       slot_match,
    input  logic       xor_pad_a_n,
    input  logic       xor_pad_b_n,
    input  logic       cmd_sys,
    input  logic       cmd_soft,
    input  logic       cmd_pll,
    output logic       hard_rst_n,
    output logic       logic_rst_n,
    output logic       reg_rst_n,
    output logic       pll_rst
);

    logic rad_vote_n;
    logic async_src_n;
    logic async_sync_n;
    logic trig_fire_n;
    logic combined_n;
    logic mask_term;

    // Radiation vote: all three cells must agree, then invert to active low
    assign rad_vote_n  = ~(&rad_hit);
    assign async_src_n = pad_rst_a_n & pad_rst_b_n & por_n & rad_vote_n;

    rstc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .async_n (async_src_n),
        .sync_n  (async_sync_n)
    );

    rstc_trig_run #(
        .RUN_LEN (TRIG_RUN)
    ) u_trig (
        .clk        (clk),
        .rst_n      (async_sync_n),
        .slot_valid (slot_valid),
        .slot_match (slot_match),
        .fire_n     (trig_fire_n)
    );

    assign combined_n = async_sync_n & trig_fire_n;
    assign mask_term  = ~(xor_pad_a_n & xor_pad_b_n);
    assign hard_rst_n = combined_n ^ mask_term;

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            logic_rst_n <= 1'b0;
            reg_rst_n   <= 1'b0;
        end else begin
            logic_rst_n <= ~(cmd_sys | cmd_soft);
            reg_rst_n   <= ~cmd_soft;
        end
    end

    rstc_pll_stretch #(
        .CYCLES (PLL_CYCLES)
    ) u_pll (
        .clk   (clk),
        .rst_n (hard_rst_n),
        .req   (cmd_pll),
        .pulse (pll_rst)
    );

    // R7: the register domain never resets without the logic domain
    a_r7_soft_nests: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !reg_rst_n |-> !logic_rst_n);

    // R6: a system command alone leaves the register domain running
    a_r6_sys_spares_regs: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (cmd_sys && !cmd_soft) |=> reg_rst_n);

    // R10: a low hard reset holds every domain in reset
    a_r10_hard_covers: assert property (@(posedge clk) disable iff (!por_n)
        !hard_rst_n |-> (!pll_rst && !logic_rst_n && !reg_rst_n));

    // R6: domain commands never raise the PLL reset
    a_r6_no_pll_side: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (!pll_rst && !cmd_pll) |=> !pll_rst);

endmodule

// File: tb/sim_chip_reset_hub.sv
module sim_chip_reset_hub;

    localparam int TRIG_RUN   = 5;
    localparam int PLL_CYCLES = 9;

    logic       clk = 1'b0;
    logic       pad_rst_a_n = 1'b1, pad_rst_b_n = 1'b1, por_n = 1'b0;
    logic [2:0] rad_hit = 3'b000;
    logic       slot_valid = 1'b0, slot_match = 1'b0;
    logic       xor_pad_a_n = 1'b1, xor_pad_b_n = 1'b1;
    logic       cmd_sys = 1'b0, cmd_soft = 1'b0, cmd_pll = 1'b0;
    logic       hard_rst_n, logic_rst_n, reg_rst_n, pll_rst;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    chip_reset_hub #(
        .TRIG_RUN   (TRIG_RUN),
        .PLL_CYCLES (PLL_CYCLES)
    ) u0 (
        .clk         (clk),
        .pad_rst_a_n (pad_rst_a_n),
        .pad_rst_b_n (pad_rst_b_n),
        .por_n       (por_n),
        .rad_hit     (rad_hit),
        .slot_valid  (slot_valid),
        .slot_match  (slot_match),
        .xor_pad_a_n (xor_pad_a_n),
        .xor_pad_b_n (xor_pad_b_n),
        .cmd_sys     (cmd_sys),
        .cmd_soft    (cmd_soft),
        .cmd_pll     (cmd_pll),
        .hard_rst_n  (hard_rst_n),
        .logic_rst_n (logic_rst_n),
        .reg_rst_n   (reg_rst_n),
        .pll_rst     (pll_rst)
    );

    // Columns: pad_a, pad_b, por, rad[2:0], xor_a, xor_b, expected hard_rst_n
    localparam int NV = 11;
    localparam logic [9:0] VEC [NV] = '{
        10'b1_1_1_000_1_1_1,
        10'b0_1_1_000_1_1_0,
        10'b1_0_1_000_1_1_0,
        10'b1_1_0_000_1_1_0,
        10'b1_1_1_111_1_1_0,
        10'b1_1_1_011_1_1_1,
        10'b1_1_1_101_1_1_1,
        10'b1_1_1_000_0_1_0,
        10'b1_1_1_000_1_0_0,
        10'b0_1_1_000_0_1_1,
        10'b1_1_1_111_0_0_1
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic match_slots(input int n);
        for (int k = 0; k < n; k++) begin
            slot_valid = 1'b1;
            slot_match = 1'b1;
            tick(1);
        end
        slot_valid = 1'b0;
        slot_match = 1'b0;
    endtask

    task automatic pll_run_check(input string req);
        for (int k = 0; k < PLL_CYCLES; k++) begin
            chk(req, pll_rst, 1'b1);
            tick(1);
        end
        chk(req, pll_rst, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Reset state under power-up reset (R2, R10)
        tick(3);
        chk("R2 por holds hard", hard_rst_n, 1'b0);
        chk("R10 logic in reset", logic_rst_n, 1'b0);
        chk("R10 reg in reset", reg_rst_n, 1'b0);
        chk("R10 pll idle", pll_rst, 1'b0);
        por_n = 1'b1;
        tick(1);
        chk("R2 release first edge", hard_rst_n, 1'b0);
        tick(1);
        chk("R2 release second edge", hard_rst_n, 1'b1);
        chk("R10 logic one edge later", logic_rst_n, 1'b0);
        tick(1);
        chk("R10 logic released", logic_rst_n, 1'b1);
        chk("R10 reg released", reg_rst_n, 1'b1);

        // Table of steady-state combinations (R1, R2, R3, R5)
        for (int i = 0; i < NV; i++) begin
            {pad_rst_a_n, pad_rst_b_n, por_n, rad_hit, xor_pad_a_n, xor_pad_b_n} = VEC[i][9:1];
            tick(4);
            chk("R1/R2/R3/R5 table", hard_rst_n, VEC[i][0]);
        end
        {pad_rst_a_n, pad_rst_b_n, por_n, rad_hit, xor_pad_a_n, xor_pad_b_n} = 9'b1_1_1_000_1_1;
        tick(4);

        // R1: pad assertion acts without a clock edge
        @(posedge clk);
        #1 pad_rst_b_n = 1'b0;
        #1 chk("R1 async assert", hard_rst_n, 1'b0);
        pad_rst_b_n = 1'b1;
        tick(4);

        // R4: run of TRIG_RUN matches fires for one cycle
        match_slots(TRIG_RUN - 1);
        chk("R4 no fire before run end", hard_rst_n, 1'b1);
        match_slots(1);
        chk("R4 fire", hard_rst_n, 1'b0);
        tick(1);
        chk("R4 fire one cycle", hard_rst_n, 1'b1);
        tick(2);

        // R4: mismatch clears the run
        match_slots(3);
        slot_valid = 1'b1; slot_match = 1'b0; tick(1);
        match_slots(3);
        chk("R4 mismatch clears", hard_rst_n, 1'b1);
        tick(1);
        chk("R4 mismatch clears later", hard_rst_n, 1'b1);
        match_slots(2);
        chk("R4 run completes", hard_rst_n, 1'b0);
        tick(3);

        // R4: idle slots neither count nor clear
        match_slots(2);
        slot_valid = 1'b0; slot_match = 1'b0; tick(2);
        match_slots(2);
        chk("R4 idle no clear", hard_rst_n, 1'b1);
        match_slots(1);
        chk("R4 idle slots skipped", hard_rst_n, 1'b0);
        tick(3);

        // R6: system command
        cmd_sys = 1'b1; tick(1); cmd_sys = 1'b0;
        chk("R6 logic pulse", logic_rst_n, 1'b0);
        chk("R6 reg spared", reg_rst_n, 1'b1);
        chk("R6 pll spared", pll_rst, 1'b0);
        tick(1);
        chk("R6 logic back", logic_rst_n, 1'b1);

        // R7: soft command
        cmd_soft = 1'b1; tick(1); cmd_soft = 1'b0;
        chk("R7 logic pulse", logic_rst_n, 1'b0);
        chk("R7 reg pulse", reg_rst_n, 1'b0);
        chk("R7 pll spared", pll_rst, 1'b0);
        tick(1);
        chk("R7 reg back", reg_rst_n, 1'b1);

        // R8: PLL pulse length and domain isolation
        cmd_pll = 1'b1; tick(1); cmd_pll = 1'b0;
        chk("R8 logic spared", logic_rst_n, 1'b1);
        chk("R8 reg spared", reg_rst_n, 1'b1);
        pll_run_check("R8 pulse length");
        tick(2);

        // R9: restart during the pulse
        cmd_pll = 1'b1; tick(1); cmd_pll = 1'b0;
        tick(4);
        cmd_pll = 1'b1; tick(1); cmd_pll = 1'b0;
        pll_run_check("R9 restart length");
        tick(2);

        // R10: hard reset cancels the PLL pulse at once
        cmd_pll = 1'b1; tick(1); cmd_pll = 1'b0;
        tick(2);
        por_n = 1'b0;
        #1 chk("R10 pll cleared", pll_rst, 1'b0);
        chk("R10 logic forced", logic_rst_n, 1'b0);
        por_n = 1'b1;
        tick(4);
        chk("R10 pll stays idle", pll_rst, 1'b0);
        chk("R10 domains back", reg_rst_n, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule